// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This controller sits next to the fetch unit of a small processor and governs the core clock around a low-power sleep. A sleep request that the core raises for one instruction cycle halts the core clock from the next instruction cycle on. A rising edge on the external interrupt pin sets a sticky interrupt flag, and the flag wakes the sequencer. Crystal-type oscillator modes then hold the core clock off while the oscillator settles for 1024 oscillator periods. RC and EC modes skip that wait.

After the wake-up, the global interrupt enable chooses the exit path. When it is set, the block runs one dummy instruction cycle and then asserts a PC load toward the fixed handler address 0x0008. The core's own +2 stepping carries on to 0x000A. When it is clear, the core resumes in line with the already prefetched instruction that follows the sleep instruction, with no load.

No data flows through this block, so every pin is a plain control or status level and there is no valid/ready handshake. Each instruction cycle lasts four oscillator clocks, Q1 to Q4. The sequencer moves only on the edge that closes Q4.

Top module: `slp_wake_seq`

## Requirements
- R1: After reset, core_clk_en is 1 and dummy_cycle, pc_load and int_flag are 0.
- R2: An instruction cycle is four clocks (Q1..Q4). The sequencer state changes only on the clock edge that ends Q4, and sleep_req is sampled on that edge.
- R3: core_clk_en is 0 from the instruction cycle after the one in which sleep_req was sampled high, and it stays 0 until the start-up wait has finished.
- R4: A rising edge of int_pin sets int_flag on the next clock. While asleep, a set flag wakes the sequencer at the next Q4 boundary.
- R5: With osc_mode 2'b00, 2'b01 or 2'b10 (crystal modes), the core clock stays off for 1024 clocks (256 instruction cycles) after the wake-up boundary.
- R6: With osc_mode 2'b11 (RC/EC), no start-up wait is inserted. The exit path begins in the instruction cycle right after the wake-up boundary.
- R7: If gie is 1 when the wait ends (or at wake-up in RC/EC mode), one instruction cycle follows with dummy_cycle=1 and core_clk_en=1. Then one cycle follows with pc_load=1 and pc_target=0x0008, and then normal running. pc_target is 0 whenever pc_load is 0.
- R8: If gie is 0 at that point, running resumes at once, with dummy_cycle and pc_load both 0.
- R9: int_flag remains 1 through the dummy and vector cycles until flag_clr is high on a clock edge. It then reads 0 on the next clock and stays 0 with no new edge.
- R10: A further int_pin edge during the start-up wait neither restarts nor lengthens it. The wait still ends 256 instruction cycles after the wake-up boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; four periods form one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction executing; sampled at the end of Q4 |
| int_pin | input | 1 | External interrupt pin; rising edge sets the flag |
| gie | input | 1 | Global interrupt enable; picks vector or in-line exit |
| osc_mode | input | 2 | 00/01/10 crystal modes with start-up wait, 11 RC/EC without |
| flag_clr | input | 1 | Clears int_flag |
| core_clk_en | output | 1 | Clock enable for the core |
| int_flag | output | 1 | Sticky external interrupt flag |
| pc_load | output | 1 | Request to load pc_target into the PC |
| pc_target | output | 16 | Handler address while pc_load is high, else 0 |
| dummy_cycle | output | 1 | Current instruction cycle is a dummy cycle |

## Verification
Any wrong sequencer state shows up within one instruction cycle on core_clk_en, dummy_cycle or pc_load. The bench samples those pins at Q2 of every instruction cycle. A start-up counter that starts wrong or is restarted moves the rising edge of core_clk_en away from the 257th instruction cycle after wake-up, so that edge is checked cycle by cycle in three oscillator modes. A flag that clears itself or fails to clear is seen on int_flag one clock after the cause.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DUMMY = 3'd3,
    ST_VECT  = 3'd4
  } seq_state_t;

  localparam logic [1:0] OSC_RCEC = 2'b11;

  function automatic logic mode_needs_wait(input logic [1:0] mode);
    return mode != OSC_RCEC;
  endfunction
endpackage

// File: rtl/slp_wake_qphase.sv
module slp_wake_qphase #(
  parameter int PHASES = 4,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          cyc_end
);
  assign cyc_end = (phase == PW'(PHASES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (cyc_end) phase <= '0;
    else              phase <= phase + 1'b1;
  end

  // R2: after the last quarter phase the count starts over at Q1
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (phase == '0));
endmodule

// File: rtl/slp_wake_ostc.sv
module slp_wake_ostc #(
  parameter int CW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + 1'b1;
    else          count <= '0;
  end

  assign done = run && (count == {CW{1'b1}});

  // R10: while the wait runs the count only steps forward, never restarts
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (count == CW'($past(count) + 1'b1)));
endmodule

// File: rtl/slp_wake_flag.sv
module slp_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic flag
);
  logic pin_q;
  logic rise;

  assign rise = pin && !pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pin_q <= pin;
      if (rise)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R9: nothing but the clear input drops the flag
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VECTOR = 16'h0008,
  parameter int              OST_W  = 10,
  parameter int              PHASES = 4,
  localparam int             PW     = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              int_pin,
  input  logic              gie,
  input  logic [1:0]        osc_mode,
  input  logic              flag_clr,
  output logic              core_clk_en,
  output logic              int_flag,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target,
  output logic              dummy_cycle
);
  import slp_wake_pkg::*;

  seq_state_t    state, state_nx;
  logic [PW-1:0] phase;
  logic          cyc_end;
  logic          ost_done;

  slp_wake_qphase #(.PHASES(PHASES)) u_qph (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cyc_end(cyc_end));

  slp_wake_ostc #(.CW(OST_W)) u_ost (
    .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT), .done(ost_done));

  slp_wake_flag u_flag (
    .clk(clk), .rst_n(rst_n), .pin(int_pin), .clr(flag_clr), .flag(int_flag));

  always_comb begin
    state_nx = state;
    if (cyc_end) begin
      unique case (state)
        ST_RUN:   if (sleep_req) state_nx = ST_SLEEP;
        ST_SLEEP: if (int_flag) begin
                    if (mode_needs_wait(osc_mode)) state_nx = ST_WAIT;
                    else                           state_nx = gie ? ST_DUMMY : ST_RUN;
                  end
        ST_WAIT:  if (ost_done) state_nx = gie ? ST_DUMMY : ST_RUN;
        ST_DUMMY: state_nx = ST_VECT;
        ST_VECT:  state_nx = ST_RUN;
        default:  state_nx = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  assign core_clk_en = (state != ST_SLEEP) && (state != ST_WAIT);
  assign dummy_cycle = (state == ST_DUMMY);
  assign pc_load     = (state == ST_VECT);
  assign pc_target   = pc_load ? VECTOR : '0;

  // R2: state moves only on the edge closing Q4
  p_state_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> ($past(phase) == PW'(PHASES - 1)));

  // R4: leaving sleep requires the interrupt flag
  p_wake_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_SLEEP && state != ST_SLEEP) |-> $past(int_flag));

  // R5: the start-up count ends exactly on an instruction-cycle boundary
  p_done_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ost_done |-> cyc_end);

  // R7: the vector load always follows a dummy cycle
  p_vector_after_dummy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_load) |-> $past(dummy_cycle));
endmodule

// File: tb/slp_wake_seq_test.sv
module slp_wake_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0, int_pin = 1'b0, gie = 1'b0, flag_clr = 1'b0;
  logic [1:0]  osc_mode = 2'b00;
  logic        core_clk_en, int_flag, pc_load, dummy_cycle;
  logic [15:0] pc_target;
  logic [1:0]  bq;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  typedef struct {
    logic  en, dum, ld, fl;
    string tag;
  } exp_t;
  exp_t sb[$];

  slp_wake_seq uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .int_pin(int_pin),
    .gie(gie), .osc_mode(osc_mode), .flag_clr(flag_clr),
    .core_clk_en(core_clk_en), .int_flag(int_flag), .pc_load(pc_load),
    .pc_target(pc_target), .dummy_cycle(dummy_cycle));

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side quarter-phase tracker (Q1=0 .. Q4=3)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bq <= 2'd0;
    else        bq <= bq + 2'd1;

  // driver: one call per instruction cycle, inputs at Q1, expectation queued
  task automatic step(input logic s, input logic p, input logic g,
                      input logic [1:0] m, input logic c,
                      input logic een, input logic edum, input logic eld,
                      input logic efl, input string tag);
    exp_t e;
    do @(negedge clk); while (bq != 2'd0);
    sleep_req = s; int_pin = p; gie = g; osc_mode = m; flag_clr = c;
    e.en = een; e.dum = edum; e.ld = eld; e.fl = efl; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic fail(input string tag, input string what,
                      input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // monitor: compare at Q2 of each instruction cycle
  always @(negedge clk) begin
    if (rst_n && bq == 2'd1 && sb.size() > 0) begin
      exp_t e;
      logic [15:0] et;
      e = sb.pop_front();
      et = e.ld ? 16'h0008 : 16'h0000;
      checks++;
      if (core_clk_en !== e.en) fail(e.tag, "core_clk_en", core_clk_en, e.en);
      if (dummy_cycle !== e.dum) fail(e.tag, "dummy_cycle", dummy_cycle, e.dum);
      if (pc_load !== e.ld) fail(e.tag, "pc_load", pc_load, e.ld);
      if (pc_target !== et) fail(e.tag, "pc_target", pc_target, et);
      if (int_flag !== e.fl) fail(e.tag, "int_flag", int_flag, e.fl);
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step(0,0,1,2'b10,0, 1,0,0,0, "R1");
    // HS mode, gie=1: crystal wait then vector
    step(1,0,1,2'b10,0, 1,0,0,0, "R2");
    step(0,0,1,2'b10,0, 0,0,0,0, "R3");
    step(0,0,1,2'b10,0, 0,0,0,0, "R3");
    step(0,1,1,2'b10,0, 0,0,0,1, "R4");
    for (int i = 0; i < 256; i++)
      step(0, (i == 10) ? 1'b0 : 1'b1, 1, 2'b10, 0, 0,0,0,1, (i > 10) ? "R10" : "R5");
    step(0,1,1,2'b10,0, 1,1,0,1, "R7");
    step(0,1,1,2'b10,0, 1,0,1,1, "R7");
    step(0,1,1,2'b10,0, 1,0,0,1, "R9");
    step(0,1,1,2'b10,1, 1,0,0,0, "R9");
    step(0,1,1,2'b10,0, 1,0,0,0, "R9");

    // RC/EC mode, gie=0: no wait, in-line resume
    step(1,0,0,2'b11,0, 1,0,0,0, "R2");
    step(0,0,0,2'b11,0, 0,0,0,0, "R3");
    step(0,1,0,2'b11,0, 0,0,0,1, "R4");
    step(0,1,0,2'b11,0, 1,0,0,1, "R6");
    step(0,1,0,2'b11,0, 1,0,0,1, "R8");
    step(0,1,0,2'b11,1, 1,0,0,0, "R9");

    // LP mode, gie=0: crystal wait then in-line resume
    step(1,0,0,2'b00,0, 1,0,0,0, "R2");
    step(0,0,0,2'b00,0, 0,0,0,0, "R3");
    step(0,1,0,2'b00,0, 0,0,0,1, "R4");
    for (int i = 0; i < 256; i++)
      step(0,1,0,2'b00,0, 0,0,0,1, "R5");
    step(0,1,0,2'b00,0, 1,0,0,1, "R8");
    step(0,1,0,2'b00,1, 1,0,0,0, "R9");

    // RC/EC, gie=1, flag already set before sleep: immediate vectoring
    step(0,0,1,2'b11,0, 1,0,0,0, "R1");
    step(0,1,1,2'b11,0, 1,0,0,1, "R4");
    step(1,1,1,2'b11,0, 1,0,0,1, "R2");
    step(0,1,1,2'b11,0, 0,0,0,1, "R3");
    step(0,1,1,2'b11,0, 1,1,0,1, "R6");
    step(0,1,1,2'b11,0, 1,0,1,1, "R7");
    step(0,1,1,2'b11,0, 1,0,0,1, "R7");

    wait (sb.size() == 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule